// File: doc/BRIEF.md
# CCD Correlated-Sampling Timing Sequencer

This block produces the per-pixel control strobes for a correlated double sampling front end that feeds a sampling converter. A pixel-start trigger lines up with the CCD reset pulse. For each accepted trigger the sequencer does four things in order. It keeps the reference sample-hold in hold through a short blanking interval so that the reset transient is not tracked. It then releases the hold so the reference level can be acquired during the quiet time. Next it holds that level while the difference signal settles. Finally it raises a one-cycle start-convert strobe, which starts the conversion on its rising edge.

The lengths of the acquisition and settling windows, and the shortest allowed pixel period, come from a two-bit analog bandwidth code. The same code drives the front end's bandwidth select lines. Each time is converted to whole cycles of a 10 ns clock by rounding up. A new code only reaches the select lines while no pixel period is running. A trigger that arrives too early is discarded and sets a sticky overrun flag.

Top module: `ccd_cds_sequencer`

## Requirements
- R1: While reset is asserted, and right after it is released, ref_hold is 1, start_conv is 0, overrun is 0 and bw_sel is 00.
- R2: A trigger is accepted when en and pix_trig are both 1 at a clock edge and no pixel period is running. ref_hold stays 1 in the first cycle after that edge, which is the one-cycle blanking interval. It is then 0 for exactly S cycles.
- R3: After acquisition, ref_hold is 1 for S cycles. start_conv is then 1 for one cycle, in cycle 2+2S counted from the accepted edge, and ref_hold is 1 during that cycle. ref_hold stays 1 until the next pixel's acquisition begins.
- R4: S depends on bw_sel: 00 gives 4 cycles (40 ns), 01 gives 8 (80 ns), 10 gives 15 (150 ns) and 11 gives 30 (300 ns).
- R5: The pixel period P depends on bw_sel: 00 gives 10, 01 gives 20, 10 gives 34 and 11 gives 84 cycles. These are 1/(10, 5, 3, 1.2 MHz), rounded up. A trigger sampled exactly P edges after the previous accepted one is accepted, so pixels can run back to back.
- R6: A trigger sampled with en=1 fewer than P edges after the last accepted one is dropped, and the running pixel carries on unchanged. overrun becomes 1 after that edge and stays 1 until reset.
- R7: While en is 0, triggers are ignored and do not set overrun. A pixel that is already running finishes normally.
- R8: When no pixel period is running, bw_sel takes the value of bw_mode one cycle later. During a pixel period bw_sel holds its value, and the new code is loaded at the edge that ends the period. If a trigger and a change of bw_mode are sampled at the same edge, the pixel uses the code already on bw_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (10 ns nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows triggers to be accepted |
| pix_trig | input | 1 | Pixel-start trigger, aligned to the CCD reset pulse |
| bw_mode | input | 2 | Requested bandwidth code |
| ref_hold | output | 1 | 1 = reference sample-hold in hold, 0 = acquire |
| start_conv | output | 1 | Conversion strobe; the conversion starts on its rising edge |
| bw_sel | output | 2 | Bandwidth select lines to the front end |
| overrun | output | 1 | Sticky flag: an early trigger was dropped |

## Verification
Two pairs of events can fall on the same clock edge: the end of a pixel period and the arrival of the next trigger, and a trigger and a change of bw_mode. The bench fires a trigger exactly P edges after the previous one and expects a new acquisition window rather than an overrun. In a separate case it changes bw_mode in the same cycle as an idle trigger. It then expects the pixel to run with the old S and bw_sel to keep the old code until that period ends. Early triggers are placed both in the middle of acquisition and at P-1 edges, and the strobe pattern is compared cycle by cycle against the pattern computed in the bench.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

  typedef logic [1:0] bw_code_t;

  localparam int NUM_MODES = 4;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // analog settling/acquisition time per bandwidth code, in ns
  function automatic int settle_ns(input int mode);
    case (mode)
      0:       return 40;
      1:       return 80;
      2:       return 150;
      default: return 300;
    endcase
  endfunction

  // maximum pixel rate per bandwidth code, in kHz
  function automatic int rate_khz(input int mode);
    case (mode)
      0:       return 10000;
      1:       return 5000;
      2:       return 3000;
      default: return 1200;
    endcase
  endfunction

  function automatic int settle_cycles(input int mode, input int clk_ns);
    return ceil_div(settle_ns(mode), clk_ns);
  endfunction

  // pixel period in cycles: never shorter than the strobe sequence itself
  function automatic int period_cycles(input int mode, input int clk_ns,
                                       input int blank, input int conv);
    int p;
    int l;
    p = ceil_div(1000000, rate_khz(mode) * clk_ns);
    l = blank + 2 * settle_cycles(mode, clk_ns) + conv;
    return (p > l) ? p : l;
  endfunction

  function automatic int max_period(input int clk_ns, input int blank, input int conv);
    int m;
    m = 0;
    for (int i = 0; i < NUM_MODES; i++) begin
      if (period_cycles(i, clk_ns, blank, conv) > m) m = period_cycles(i, clk_ns, blank, conv);
    end
    return m;
  endfunction

endpackage

// File: rtl/ccdseq_mode_rom.sv
module ccdseq_mode_rom
  import ccdseq_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int BLANK_CYC = 1,
  parameter int CONV_CYC  = 1,
  parameter int CNT_W     = 7
) (
  input  bw_code_t           code,
  output logic [CNT_W-1:0]   settle,
  output logic [CNT_W-1:0]   period
);

  logic [CNT_W-1:0] settle_tab [NUM_MODES];
  logic [CNT_W-1:0] period_tab [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    localparam int S_CYC = settle_cycles(g, CLK_NS);
    localparam int P_CYC = period_cycles(g, CLK_NS, BLANK_CYC, CONV_CYC);
    assign settle_tab[g] = CNT_W'(S_CYC);
    assign period_tab[g] = CNT_W'(P_CYC);
  end

  assign settle = settle_tab[code];
  assign period = period_tab[code];

endmodule

// File: rtl/ccdseq_period_ctrl.sv
module ccdseq_period_ctrl
  import ccdseq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pix_trig,
  input  bw_code_t         bw_mode,
  input  logic [CNT_W-1:0] mode_settle,
  input  logic [CNT_W-1:0] mode_period,
  output bw_code_t         bw_sel,
  output logic             busy_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] settle_d,
  output logic             overrun
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] settle_q;
  bw_code_t         sel_q;
  logic             ovr_q;

  logic at_lim, trig_v, accept, drop, ending;
  logic [CNT_W-1:0] lim_d;
  bw_code_t         sel_d;

  always_comb begin
    at_lim   = busy_q && (cnt_q == lim_q);
    trig_v   = en && pix_trig;
    accept   = trig_v && (!busy_q || at_lim);
    drop     = trig_v && busy_q && !at_lim;
    ending   = at_lim && !accept;

    busy_d   = accept || (busy_q && !ending);
    if (accept)      cnt_d = CNT_W'(1);
    else if (busy_d) cnt_d = cnt_q + 1'b1;
    else             cnt_d = '0;

    settle_d = accept ? mode_settle : settle_q;
    lim_d    = accept ? mode_period : lim_q;
    sel_d    = ((!busy_q || ending) && !accept) ? bw_mode : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= '0;
      settle_q <= '0;
      sel_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      cnt_q    <= cnt_d;
      lim_q    <= lim_d;
      settle_q <= settle_d;
      sel_q    <= sel_d;
      if (drop) ovr_q <= 1'b1;
    end
  end

  assign bw_sel  = sel_q;
  assign overrun = ovr_q;

  // R5
  cnt_within_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= lim_q));

  // R6
  drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovr_q);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);

  // R6
  drop_keeps_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (busy_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R7
  disabled_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy_q) |=> !busy_q);

  // R8
  sel_frozen_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_lim) |=> $stable(sel_q));

endmodule

// File: rtl/ccdseq_strobe_gen.sv
module ccdseq_strobe_gen #(
  parameter int BLANK_CYC = 1,
  parameter int CONV_CYC  = 1,
  parameter int CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] settle_d,
  output logic             ref_hold,
  output logic             start_conv
);

  localparam int EW = CNT_W + 2;

  logic [EW-1:0] c_x, s_x, acq_lo, acq_hi, conv_lo, conv_hi;
  logic          in_acq, in_conv;

  always_comb begin
    c_x     = EW'(cnt_d);
    s_x     = EW'(settle_d);
    acq_lo  = EW'(BLANK_CYC) + 1'b1;
    acq_hi  = EW'(BLANK_CYC) + s_x;
    conv_lo = acq_hi + s_x + 1'b1;
    conv_hi = acq_hi + s_x + EW'(CONV_CYC);
    in_acq  = busy_d && (c_x >= acq_lo) && (c_x <= acq_hi);
    in_conv = busy_d && (c_x >= conv_lo) && (c_x <= conv_hi);
  end

  logic             hold_q, conv_q;
  logic [CNT_W-1:0] settle_r, low_run, high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= 1'b1;
      conv_q   <= 1'b0;
      settle_r <= '0;
      low_run  <= '0;
      high_run <= '0;
    end else begin
      hold_q   <= !in_acq;
      conv_q   <= in_conv;
      settle_r <= settle_d;
      low_run  <= hold_q ? '0 : low_run + 1'b1;
      if (!hold_q)        high_run <= '0;
      else if (~&high_run) high_run <= high_run + 1'b1;
    end
  end

  assign ref_hold   = hold_q;
  assign start_conv = conv_q;

  // R3
  conv_inside_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_q |-> hold_q);

  // R3
  conv_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CONV_CYC == 1 && conv_q) |=> !conv_q);

  // R3
  conv_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_q) |-> (high_run >= settle_r));

  // R2
  acq_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> (low_run == settle_r));

endmodule

// File: rtl/ccd_cds_sequencer.sv
module ccd_cds_sequencer
  import ccdseq_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int BLANK_CYC = 1,
  parameter int CONV_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pix_trig,
  input  logic [1:0] bw_mode,
  output logic       ref_hold,
  output logic       start_conv,
  output logic [1:0] bw_sel,
  output logic       overrun
);

  localparam int MAX_P = max_period(CLK_NS, BLANK_CYC, CONV_CYC);
  localparam int CNT_W = $clog2(MAX_P + 1);

  bw_code_t         sel_w;
  logic [CNT_W-1:0] mode_settle, mode_period, cnt_d, settle_d;
  logic             busy_d;

  ccdseq_mode_rom #(
    .CLK_NS(CLK_NS), .BLANK_CYC(BLANK_CYC), .CONV_CYC(CONV_CYC), .CNT_W(CNT_W)
  ) u_rom (
    .code   (sel_w),
    .settle (mode_settle),
    .period (mode_period)
  );

  ccdseq_period_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .pix_trig    (pix_trig),
    .bw_mode     (bw_mode),
    .mode_settle (mode_settle),
    .mode_period (mode_period),
    .bw_sel      (sel_w),
    .busy_d      (busy_d),
    .cnt_d       (cnt_d),
    .settle_d    (settle_d),
    .overrun     (overrun)
  );

  ccdseq_strobe_gen #(
    .BLANK_CYC(BLANK_CYC), .CONV_CYC(CONV_CYC), .CNT_W(CNT_W)
  ) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_d     (busy_d),
    .cnt_d      (cnt_d),
    .settle_d   (settle_d),
    .ref_hold   (ref_hold),
    .start_conv (start_conv)
  );

  assign bw_sel = sel_w;

endmodule

// File: tb/ccd_cds_sequencer_bench.sv
module ccd_cds_sequencer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       pix_trig = 1'b0;
  logic [1:0] bw_mode = 2'b00;
  logic       ref_hold, start_conv, overrun;
  logic [1:0] bw_sel;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ccd_cds_sequencer u_ccd_cds_sequencer (
    .clk(clk), .rst_n(rst_n), .en(en), .pix_trig(pix_trig), .bw_mode(bw_mode),
    .ref_hold(ref_hold), .start_conv(start_conv), .bw_sel(bw_sel), .overrun(overrun)
  );

  // {code, S cycles, P cycles}
  localparam int VEC [4][3] = '{'{0, 4, 10}, '{1, 8, 20}, '{2, 15, 34}, '{3, 30, 84}};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fire();
    pix_trig = 1'b1;
    tick();
    pix_trig = 1'b0;
  endtask

  function automatic bit exp_hold(input int c, input int s);
    return !(c >= 2 && c <= 1 + s);
  endfunction

  // entered with cycle index 1 showing; leaves with index P showing,
  // or with a new pixel at index 1 when chain is set
  task automatic walk_pixel(input int s, input int p, input bit chain, input string req);
    for (int i = 1; i <= p; i++) begin
      chk(ref_hold == exp_hold(i, s), req, $sformatf("ref_hold c=%0d", i),
          ref_hold, exp_hold(i, s));
      chk(start_conv == (i == 2 + 2 * s), req, $sformatf("start_conv c=%0d", i),
          start_conv, (i == 2 + 2 * s));
      if (i < p) tick();
      else if (chain) fire();
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) tick();
    chk(ref_hold == 1'b1 && start_conv == 1'b0, "R1", "strobes in reset",
        {ref_hold, start_conv}, 2);
    chk(overrun == 1'b0 && bw_sel == 2'b00, "R1", "flag/sel in reset",
        {overrun, bw_sel}, 0);
    rst_n = 1'b1;
    tick();
    chk(ref_hold == 1'b1 && start_conv == 1'b0 && overrun == 1'b0 && bw_sel == 2'b00,
        "R1", "after release", {ref_hold, start_conv, overrun, bw_sel}, 8);
    en = 1'b1;

    // table walk: R2 R3 R4 per code, then R5 back-to-back
    for (int v = 0; v < 4; v++) begin
      bw_mode = 2'(VEC[v][0]);
      tick();
      tick();
      chk(bw_sel == 2'(VEC[v][0]), "R8", "idle sel follows mode", bw_sel, VEC[v][0]);
      fire();
      walk_pixel(VEC[v][1], VEC[v][2], 1'b1, "R2 R3 R4");
      walk_pixel(VEC[v][1], VEC[v][2], 1'b0, "R5");
      chk(overrun == 1'b0, "R5", "no overrun at exact period", overrun, 0);
      tick();
    end

    // R7: disabled triggers ignored
    bw_mode = 2'b00;
    tick();
    tick();
    en = 1'b0;
    fire();
    for (int i = 0; i < 8; i++) begin
      chk(ref_hold == 1'b1 && start_conv == 1'b0, "R7", "no pixel while disabled",
          {ref_hold, start_conv}, 2);
      tick();
    end
    chk(overrun == 1'b0, "R7", "no overrun while disabled", overrun, 0);
    en = 1'b1;
    fire();
    en = 1'b0;
    pix_trig = 1'b1;
    walk_pixel(4, 10, 1'b0, "R7");
    pix_trig = 1'b0;
    tick();
    chk(overrun == 1'b0, "R7", "disabled trig mid-pixel no flag", overrun, 0);
    en = 1'b1;

    // R8: mode change during a running period
    fire();
    for (int i = 1; i <= 10; i++) begin
      chk(bw_sel == 2'b00, "R8", $sformatf("sel held c=%0d", i), bw_sel, 0);
      if (i == 2) bw_mode = 2'b11;
      tick();
    end
    chk(bw_sel == 2'b11, "R8", "sel loaded at period end", bw_sel, 3);

    // R8: trigger and mode change on the same edge
    bw_mode = 2'b01;
    tick();
    tick();
    bw_mode = 2'b10;
    fire();
    chk(bw_sel == 2'b01, "R8", "sel unchanged at trigger", bw_sel, 1);
    walk_pixel(8, 20, 1'b0, "R8");
    chk(bw_sel == 2'b01, "R8", "sel held to end", bw_sel, 1);
    tick();
    chk(bw_sel == 2'b10, "R8", "sel after period", bw_sel, 2);

    // R6: early triggers during acquisition and at P-1
    fire();
    for (int i = 1; i <= 34; i++) begin
      chk(ref_hold == exp_hold(i, 15) && start_conv == (i == 32), "R6",
          $sformatf("pixel unchanged c=%0d", i), {ref_hold, start_conv},
          {exp_hold(i, 15), (i == 32)});
      if (i == 6) chk(overrun == 1'b1, "R6", "flag after early trigger", overrun, 1);
      if (i == 5 || i == 33) pix_trig = 1'b1;
      if (i < 34) tick();
      pix_trig = 1'b0;
    end
    tick();
    for (int i = 0; i < 32; i++) begin
      chk(ref_hold == 1'b1 && start_conv == 1'b0, "R6", "dropped trigger no pixel",
          {ref_hold, start_conv}, 2);
      tick();
    end
    chk(overrun == 1'b1, "R6", "flag sticky", overrun, 1);
    fire();
    walk_pixel(15, 34, 1'b0, "R6");
    tick();
    chk(overrun == 1'b1, "R6", "flag survives later pixel", overrun, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule